// File: doc/BRIEF.md
# Ultra DMA Burst CRC Checker with First-Error Hold

This block sits on the device side of an Ultra DMA link and checks data integrity for each command. While the host holds its DMA acknowledge low, every 16-bit word marked by the word strobe is folded into a running CRC. The CRC uses the polynomial x^16+x^12+x^5+1 and is seeded afresh for each burst. When the acknowledge is released, the block takes the host's CRC word from the data bus. One cycle later it compares that word with its own result and raises a per-burst verdict.

Over a whole command, which may contain several bursts, the block keeps only the first miscompare. It holds the expected CRC, the received CRC and the index of the burst that failed. A command-end pulse then presents this record. The block also drives the enable of the device strobe and drops it shortly after the host releases the acknowledge, so the strobe line is let go. Generating bus timing is left to the surrounding logic.

Top module: `ucrc_checker`

## Requirements
- R1: After a synchronous reset, dstrb_oe, burst_done, burst_bad, stat_vld and stat_err are 0, and stat_exp, stat_rcv and stat_idx are 0.
- R2: For each burst the expected CRC starts at 16'h4ABA. Each accepted word d updates the CRC MSB first: per bit, fb = crc[15]^d[i], then crc shifts left by one and is XORed with 16'h1021 when fb is 1. burst_bad is 1 exactly when the host word differs from this value.
- R3: A word strobe is accepted only while the synchronized dmack_n has been low for at least one cycle past its falling edge. Strobes while dmack_n is high leave the CRC untouched.
- R4: The host CRC is taken from dd in the cycle the synchronized dmack_n rises. Later changes of dd do not affect that burst's verdict.
- R5: burst_done is a one-cycle pulse that is high after the 4th rising clock edge following the rise of dmack_n. burst_bad is valid with it and is never high without it.
- R6: The first miscompare in a command stores stat_exp (device CRC), stat_rcv (host CRC) and stat_idx (burst index within the command, counting from 0), and sets stat_err. Later miscompares leave them unchanged.
- R7: A cmd_start pulse clears stat_err, stat_exp, stat_rcv, stat_idx and the burst count.
- R8: A cmd_end pulse makes stat_vld high for exactly the following cycle, with stat_err and the held record readable alongside it.
- R9: dstrb_oe rises at the 3rd rising edge after dmack_n falls, and falls at the 3rd rising edge after dmack_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmack_n | input | 1 | Host DMA acknowledge, active low, asynchronous |
| word_stb | input | 1 | One-cycle mark of a transferred data word |
| dd | input | 16 | Data bus: data words, then the host CRC at burst end |
| cmd_start | input | 1 | Command begins; clears the error record |
| cmd_end | input | 1 | Command ends; requests the status report |
| dstrb_oe | output | 1 | Output enable of the device strobe |
| burst_done | output | 1 | Per-burst comparison valid |
| burst_bad | output | 1 | Per-burst CRC miscompare |
| stat_vld | output | 1 | Command status report valid |
| stat_err | output | 1 | A miscompare occurred in this command |
| stat_exp | output | 16 | Device CRC of the first failing burst |
| stat_rcv | output | 16 | Host CRC of the first failing burst |
| stat_idx | output | 4 | Index of the first failing burst |

## Verification
A wrong running CRC or a missed seed shows up as a false burst_bad on the next burst_done, four clocks after the acknowledge rises. A record that is overwritten, or that is not cleared, changes stat_exp, stat_rcv or stat_idx as seen at the next cmd_end report. Errors in the synchronizer or in edge detection move dstrb_oe and burst_done by whole cycles. The bench samples every edge-relative position explicitly, so such shifts are caught.

// File: rtl/ucrc_pkg.sv
package ucrc_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t exp_crc;
        word_t rcv_crc;
    } crc_pair_t;

    function automatic word_t crc_word(word_t cur, word_t din, word_t poly);
        word_t c;
        logic  fb;
        c = cur;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[WORD_W-1] ^ din[i];
            c  = {c[WORD_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/ucrc_edge_sync.sv
module ucrc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic act,
    output logic asrt_edge,
    output logic neg_edge
);
    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[LEN-2:0], async_n};
    end

    assign asrt_edge = !sh[LEN-2] &&  sh[LEN-1];
    assign neg_edge  =  sh[LEN-2] && !sh[LEN-1];
    assign act       = !sh[LEN-2] && !sh[LEN-1];
endmodule

// File: rtl/ucrc_accum.sv
module ucrc_accum
    import ucrc_pkg::*;
#(
    parameter word_t POLY = 16'h1021,
    parameter word_t SEED = 16'h4ABA
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      seed_ld,
    input  logic      word_ok,
    input  word_t     dd,
    input  logic      cap,
    output logic      cmp_vld,
    output logic      cmp_bad,
    output crc_pair_t pair
);
    word_t crc_q;
    logic  cap_d;

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= SEED;
        else if (seed_ld) crc_q <= SEED;
        else if (word_ok) crc_q <= crc_word(crc_q, dd, POLY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair    <= '0;
            cap_d   <= 1'b0;
            cmp_vld <= 1'b0;
            cmp_bad <= 1'b0;
        end else begin
            cap_d   <= cap;
            if (cap) begin
                pair.exp_crc <= crc_q;
                pair.rcv_crc <= dd;
            end
            cmp_vld <= cap_d;
            cmp_bad <= cap_d && (pair.exp_crc != pair.rcv_crc);
        end
    end
endmodule

// File: rtl/ucrc_first_err.sv
module ucrc_first_err
    import ucrc_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             cmd_end,
    input  logic             cmp_vld,
    input  logic             cmp_bad,
    input  crc_pair_t        pair,
    output logic             err_flag,
    output crc_pair_t        rec,
    output logic [IDX_W-1:0] rec_idx,
    output logic             rpt_vld
);
    logic [IDX_W-1:0] burst_cnt;

    always_ff @(posedge clk) begin
        if (rst || cmd_start) begin
            err_flag  <= 1'b0;
            rec       <= '0;
            rec_idx   <= '0;
            burst_cnt <= '0;
        end else if (cmp_vld) begin
            burst_cnt <= burst_cnt + 1'b1;
            if (cmp_bad && !err_flag) begin
                err_flag <= 1'b1;
                rec      <= pair;
                rec_idx  <= burst_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rpt_vld <= 1'b0;
        else     rpt_vld <= cmd_end;
    end
endmodule

// File: rtl/ucrc_checker.sv
module ucrc_checker
    import ucrc_pkg::*;
#(
    parameter logic [15:0] POLY  = 16'h1021,
    parameter logic [15:0] SEED  = 16'h4ABA,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dmack_n,
    input  logic             word_stb,
    input  logic [15:0]      dd,
    input  logic             cmd_start,
    input  logic             cmd_end,
    output logic             dstrb_oe,
    output logic             burst_done,
    output logic             burst_bad,
    output logic             stat_vld,
    output logic             stat_err,
    output logic [15:0]      stat_exp,
    output logic [15:0]      stat_rcv,
    output logic [IDX_W-1:0] stat_idx
);
    logic      ack_act, ack_asrt, ack_neg;
    crc_pair_t cur_pair, held_pair;

    ucrc_edge_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .async_n   (dmack_n),
        .act       (ack_act),
        .asrt_edge (ack_asrt),
        .neg_edge  (ack_neg)
    );

    ucrc_accum #(.POLY(POLY), .SEED(SEED)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .seed_ld (ack_asrt),
        .word_ok (word_stb && ack_act),
        .dd      (dd),
        .cap     (ack_neg),
        .cmp_vld (burst_done),
        .cmp_bad (burst_bad),
        .pair    (cur_pair)
    );

    ucrc_first_err #(.IDX_W(IDX_W)) u_first (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd_end   (cmd_end),
        .cmp_vld   (burst_done),
        .cmp_bad   (burst_bad),
        .pair      (cur_pair),
        .err_flag  (stat_err),
        .rec       (held_pair),
        .rec_idx   (stat_idx),
        .rpt_vld   (stat_vld)
    );

    assign stat_exp = held_pair.exp_crc;
    assign stat_rcv = held_pair.rcv_crc;

    always_ff @(posedge clk) begin
        if (rst)           dstrb_oe <= 1'b0;
        else if (ack_asrt) dstrb_oe <= 1'b1;
        else if (ack_neg)  dstrb_oe <= 1'b0;
    end
endmodule

// File: rtl/ucrc_checker_sva.sv
module ucrc_checker_sva #(
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             dmack_n,
    input logic             cmd_start,
    input logic             cmd_end,
    input logic             dstrb_oe,
    input logic             burst_done,
    input logic             burst_bad,
    input logic             stat_vld,
    input logic             stat_err,
    input logic [15:0]      stat_exp,
    input logic [15:0]      stat_rcv,
    input logic [IDX_W-1:0] stat_idx
);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);

    // R5
    bad_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        burst_bad |-> burst_done);

    // R5
    done_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> $past(dmack_n, 2));

    // R6
    first_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_err && !cmd_start) |=> (stat_err && $stable(stat_exp)
                                      && $stable(stat_rcv) && $stable(stat_idx)));

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (!stat_err && stat_idx == '0 && stat_exp == '0));

    // R8
    report_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_end |=> stat_vld);

    // R8
    report_source_chk: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> $past(cmd_end));

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dstrb_oe) |-> $past(dmack_n));
endmodule

bind ucrc_checker ucrc_checker_sva #(.IDX_W(IDX_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .dmack_n    (dmack_n),
    .cmd_start  (cmd_start),
    .cmd_end    (cmd_end),
    .dstrb_oe   (dstrb_oe),
    .burst_done (burst_done),
    .burst_bad  (burst_bad),
    .stat_vld   (stat_vld),
    .stat_err   (stat_err),
    .stat_exp   (stat_exp),
    .stat_rcv   (stat_rcv),
    .stat_idx   (stat_idx)
);

// File: tb/ucrc_checker_test.sv
module ucrc_checker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dmack_n = 1'b1;
    logic        word_stb = 1'b0;
    logic [15:0] dd = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_end = 1'b0;
    logic        dstrb_oe, burst_done, burst_bad, stat_vld, stat_err;
    logic [15:0] stat_exp, stat_rcv;
    logic [3:0]  stat_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit exp_q[$];

    always #4 clk = ~clk;

    ucrc_checker uut (
        .clk(clk), .rst(rst), .dmack_n(dmack_n), .word_stb(word_stb), .dd(dd),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .dstrb_oe(dstrb_oe),
        .burst_done(burst_done), .burst_bad(burst_bad), .stat_vld(stat_vld),
        .stat_err(stat_err), .stat_exp(stat_exp), .stat_rcv(stat_rcv),
        .stat_idx(stat_idx)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Reference CRC: word XORed into the top, then 16 shifts.
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r;
        r = c ^ w;
        repeat (16) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    // Scoreboard monitor: compares every per-burst verdict.
    always @(negedge clk) begin
        if (!rst && burst_done) begin
            if (exp_q.size() == 0) chk("R5 unexpected burst_done", 1, 0);
            else chk("R2 burst_bad verdict", {31'b0, burst_bad}, {31'b0, exp_q.pop_front()});
        end
    end

    task automatic run_burst(input int nw, input logic [15:0] base, input logic [15:0] flip,
                             output logic [15:0] crc_o, output logic [15:0] rcv_o);
        logic [15:0] c;
        c = 16'h4ABA;
        @(negedge clk) dmack_n = 1'b0;
        @(negedge clk);
        @(negedge clk) chk("R9 oe low before 3rd edge", {31'b0, dstrb_oe}, 0);
        @(negedge clk) chk("R9 oe high at 3rd edge", {31'b0, dstrb_oe}, 1);
        for (int i = 0; i < nw; i++) begin
            dd = base + 16'(i) * 16'h1357;
            word_stb = 1'b1;
            c = ref_crc(c, dd);
            @(negedge clk) word_stb = 1'b0;
            if (i % 2 == 1) @(negedge clk);
        end
        dd = c ^ flip;
        crc_o = c;
        rcv_o = c ^ flip;
        exp_q.push_back(flip != 16'h0);
        @(negedge clk) dmack_n = 1'b1;
        @(negedge clk);
        @(negedge clk) begin
            chk("R9 oe held at 2nd edge", {31'b0, dstrb_oe}, 1);
            chk("R5 no verdict yet", {31'b0, burst_done}, 0);
        end
        @(negedge clk) chk("R9 oe released at 3rd edge", {31'b0, dstrb_oe}, 0);
        @(negedge clk) chk("R5 verdict at 4th edge", {31'b0, burst_done}, 1);
        // R4: bus changes after capture; R3: stray strobe while idle
        dd = 16'hDEAD;
        word_stb = 1'b1;
        @(negedge clk) begin
            word_stb = 1'b0;
            chk("R5 verdict one cycle", {31'b0, burst_done}, 0);
        end
    endtask

    task automatic start_cmd();
        @(negedge clk) cmd_start = 1'b1;
        @(negedge clk) begin
            cmd_start = 1'b0;
            chk("R7 err cleared", {31'b0, stat_err}, 0);
            chk("R7 idx cleared", {28'b0, stat_idx}, 0);
            chk("R7 exp cleared", {16'b0, stat_exp}, 0);
        end
    endtask

    task automatic end_cmd(input logic err_e);
        @(negedge clk) cmd_end = 1'b1;
        @(negedge clk) begin
            cmd_end = 1'b0;
            chk("R8 stat_vld pulse", {31'b0, stat_vld}, 1);
            chk("R8 stat_err reported", {31'b0, stat_err}, {31'b0, err_e});
        end
        @(negedge clk) chk("R8 stat_vld one cycle", {31'b0, stat_vld}, 0);
    endtask

    initial begin
        logic [15:0] c0, r0, c1, r1, c2, r2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 dstrb_oe", {31'b0, dstrb_oe}, 0);
        chk("R1 burst_done", {31'b0, burst_done}, 0);
        chk("R1 stat_vld", {31'b0, stat_vld}, 0);
        chk("R1 stat_err", {31'b0, stat_err}, 0);
        chk("R1 record", {stat_exp, stat_rcv}, 0);

        // Command 1: clean bursts, stray strobes while idle (R3)
        start_cmd();
        dd = 16'h1111; word_stb = 1'b1;
        @(negedge clk) word_stb = 1'b0;
        run_burst(3, 16'h0102, 16'h0, c0, r0);
        run_burst(5, 16'hF00F, 16'h0, c1, r1);
        end_cmd(1'b0);

        // Command 2: first miscompare held, later one ignored (R6)
        start_cmd();
        run_burst(4, 16'hA5A5, 16'h0, c0, r0);
        run_burst(2, 16'h7E01, 16'h0001, c1, r1);
        run_burst(6, 16'h0000, 16'h8000, c2, r2);
        end_cmd(1'b1);
        chk("R6 stat_exp first error", {16'b0, stat_exp}, {16'b0, c1});
        chk("R6 stat_rcv first error", {16'b0, stat_rcv}, {16'b0, r1});
        chk("R6 stat_idx first error", {28'b0, stat_idx}, 1);

        // Command 3: clear, then a burst with no words (R2 seed only)
        start_cmd();
        run_burst(0, 16'h0, 16'h0, c0, r0);
        chk("R2 empty burst crc is seed", {16'b0, c0}, 32'h4ABA);
        run_burst(1, 16'hFFFF, 16'h0, c1, r1);
        end_cmd(1'b0);

        repeat (3) @(negedge clk);
        chk("R5 all verdicts seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule